// File: doc/BRIEF.md
# Per-Thread Line-Buffered Instruction Fetch Slicer

This block sits at the front of a multithreaded instruction fetch pipeline. It keeps one instruction cache line per hardware thread, tagged with the line address it was requested for. In any cycle one thread presents a fetch PC. The block first decides whether that thread's buffered line already covers the PC. On a miss it issues a line request to memory. On a hit it cuts up to `WIDTH` fixed four-byte instructions out of the buffered line and registers them into decode-bound slots, each with a sequence number. It also computes the PC that the thread should fetch from next.

The branch predictor and the opcode decoder live outside the block. For every slot they supply a predicted-taken bit, a predicted target and a quiesce-opcode flag. A translation fault flag arrives alongside the fetch PC. A faulting access is passed downstream as a single no-op that carries the fault. Quiesce instructions and faults park the thread until a restart pulse names it again. Line fills return tagged with the thread number.

Top module: `fx_fetch_top`

## Requirements
- R1: On a fetch from a thread in state RUN (0) that misses its buffer and is not held, `mem_req_valid` is high in the same cycle, with `mem_req_tid` equal to the thread and `mem_req_addr` equal to the fetch PC with its low log2(LINE_BYTES) bits cleared. From the next cycle the thread's `thr_state` field (bits 2t+1:2t) reads WAIT (1), its buffer is invalid and its tag is the new line address.
- R2: A fetch whose aligned address equals the valid tag of the thread's buffer issues no memory request and extracts instructions from the buffer.
- R3: While `cache_blocked` is high, or while `intr_pending` is high and fetch PC bits [1:0] are nonzero, a fetch issues no request, produces no slots and leaves the thread state unchanged.
- R4: Extraction starts at word index (PC mod LINE_BYTES)/4. Slot i holds line word start+i (word k at `fill_data` bits 32k+31:32k) and reports PC line_base+4·(start+i).
- R5: Extraction stops at whichever comes first: the end of the line, WIDTH slots, or a slot with `pred_taken` or `slot_quiesce` set. That slot is itself emitted.
- R6: `out_next_pc` is the target of the stopping taken slot (`pred_target` bits AW·i+AW−1:AW·i). Otherwise it is the fetch PC plus four times the slot count.
- R7: Emitted slots carry consecutive sequence numbers (SW bits, wrapping) from a counter that starts at 0 after reset and advances by the number of slots emitted.
- R8: Slots not filled in a cycle have their `out_valid` bit at 0. Valid slots form a prefix from slot 0, and `out_count` equals their number.
- R9: If an emitted slot has `slot_quiesce` set, the thread moves to QUIESCE (2). Further fetches for it produce nothing until a `restart_valid` pulse returns it to RUN.
- R10: A fetch that misses, is not held and has `fetch_fault` set issues no request. It emits one slot whose instruction is `NOP_CODE` with `out_fault` high, and `out_next_pc` equals the fetch PC. The thread moves to TRAP (3). `fetch_fault` has no effect on a buffer hit.
- R11: A fill is accepted only for a thread in WAIT. It loads the data, validates the buffer and returns the thread to RUN. Any other fill is ignored. A restart in the same cycle takes priority, so the fill is dropped.
- R12: Slot outputs, `out_count`, `out_fault`, `out_tid` and `out_next_pc` appear on the clock edge that ends the fetch cycle. The memory request is combinational in the fetch cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_en | input | 1 | A thread fetches this cycle |
| fetch_tid | input | TIDW | Fetching thread |
| fetch_pc | input | AW | Fetch PC |
| fetch_fault | input | 1 | Translation or bad-address fault for this access |
| cache_blocked | input | 1 | Memory side cannot accept a request |
| intr_pending | input | 1 | Interrupt waiting to be taken |
| pred_taken | input | WIDTH | Per-slot predicted-taken flag |
| pred_target | input | WIDTH*AW | Per-slot predicted target |
| slot_quiesce | input | WIDTH | Per-slot quiesce-opcode flag |
| fill_valid | input | 1 | Line fill returning |
| fill_tid | input | TIDW | Thread of the fill |
| fill_data | input | LINE_BYTES*8 | Line contents |
| restart_valid | input | 1 | Return a thread to RUN |
| restart_tid | input | TIDW | Thread to restart |
| mem_req_valid | output | 1 | Line request |
| mem_req_tid | output | TIDW | Requesting thread |
| mem_req_addr | output | AW | Aligned line address |
| out_valid | output | WIDTH | Slot valid bits |
| out_insn | output | WIDTH*IW | Slot instructions |
| out_pc | output | WIDTH*AW | Slot PCs |
| out_seq | output | WIDTH*SW | Slot sequence numbers |
| out_fault | output | 1 | Slot 0 carries a fault |
| out_count | output | CW | Number of valid slots |
| out_tid | output | TIDW | Thread of the slots |
| out_next_pc | output | AW | Next fetch PC for that thread |
| thr_state | output | NTHR*2 | Per-thread state, 2 bits each |

## Verification
A stale tag or a lost valid bit shows up in the fetch cycle itself. Either a request appears for a line that is already held, or a hit slices old words that the bench can tell apart because every word encodes its thread, line and index. A wrong start offset, stop rule or sequence step appears one edge later as a wrong `out_count`, slot word, slot PC or sequence number. A state slip surfaces on `thr_state` at the next edge, and on the following fetch as slots from a parked thread or a missing request.

// File: rtl/fx_pkg.sv
package fx_pkg;
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_WAIT    = 2'd1,
    ST_QUIESCE = 2'd2,
    ST_TRAP    = 2'd3
  } thr_st_e;

  localparam int INSN_BYTES = 4;
endpackage

// File: rtl/fx_linebuf.sv
module fx_linebuf #(
  parameter int NTHR       = 2,
  parameter int AW         = 16,
  parameter int LINE_BYTES = 16,
  parameter int TIDW       = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_we,
  input  logic [TIDW-1:0]         req_tid,
  input  logic [AW-1:0]           req_tag,
  input  logic                    fill_we,
  input  logic [TIDW-1:0]         fill_tid,
  input  logic [LINE_BYTES*8-1:0] fill_data,
  input  logic [TIDW-1:0]         rd_tid,
  output logic [AW-1:0]           rd_tag,
  output logic                    rd_valid,
  output logic [LINE_BYTES*8-1:0] rd_data
);
  localparam int LBITS = LINE_BYTES * 8;

  logic [AW-1:0]    tag_q [NTHR];
  logic             vld_q [NTHR];
  logic [LBITS-1:0] dat_q [NTHR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < NTHR; t++) begin
        tag_q[t] <= '0;
        vld_q[t] <= 1'b0;
        dat_q[t] <= '0;
      end
    end else begin
      for (int t = 0; t < NTHR; t++) begin
        if (req_we && req_tid == TIDW'(t)) begin
          tag_q[t] <= req_tag;
          vld_q[t] <= 1'b0;
        end
        if (fill_we && fill_tid == TIDW'(t)) begin
          dat_q[t] <= fill_data;
          vld_q[t] <= 1'b1;
        end
      end
    end
  end

  assign rd_tag   = tag_q[rd_tid];
  assign rd_valid = vld_q[rd_tid];
  assign rd_data  = dat_q[rd_tid];
endmodule

// File: rtl/fx_slicer.sv
module fx_slicer #(
  parameter int AW         = 16,
  parameter int IW         = 32,
  parameter int LINE_BYTES = 16,
  parameter int WIDTH      = 3,
  parameter int CW         = 2
) (
  input  logic [AW-1:0]           pc,
  input  logic [LINE_BYTES*8-1:0] line_data,
  input  logic [WIDTH-1:0]        pred_taken,
  input  logic [WIDTH*AW-1:0]     pred_target,
  input  logic [WIDTH-1:0]        slot_quiesce,
  output logic [WIDTH-1:0]        slot_valid,
  output logic [WIDTH*IW-1:0]     slot_insn,
  output logic [WIDTH*AW-1:0]     slot_pc,
  output logic [CW-1:0]           slot_count,
  output logic [AW-1:0]           next_pc,
  output logic                    quiesce_hit
);
  import fx_pkg::*;

  localparam int WORDS = LINE_BYTES / INSN_BYTES;
  localparam int OFFW  = $clog2(LINE_BYTES);

  function automatic logic [AW-1:0] advance_pc(input logic [AW-1:0] p, input logic [CW-1:0] n);
    return p + (AW'(n) << 2);
  endfunction

  function automatic int start_word(input logic [AW-1:0] p);
    return int'(p[OFFW-1:2]);
  endfunction

  logic [AW-1:0] line_base;
  logic          taken_hit;
  logic [AW-1:0] taken_tgt;
  logic          stop;
  int            k;

  assign line_base = {pc[AW-1:OFFW], OFFW'(0)};

  always_comb begin
    slot_valid  = '0;
    slot_insn   = '0;
    slot_pc     = '0;
    slot_count  = '0;
    taken_hit   = 1'b0;
    taken_tgt   = '0;
    quiesce_hit = 1'b0;
    stop        = 1'b0;
    k           = 0;
    for (int i = 0; i < WIDTH; i++) begin
      k = start_word(pc) + i;
      if (!stop && k < WORDS) begin
        slot_valid[i]          = 1'b1;
        slot_insn[i*IW +: IW]  = line_data[k*IW +: IW];
        slot_pc[i*AW +: AW]    = line_base + AW'(k * INSN_BYTES);
        slot_count             = slot_count + CW'(1);
        if (pred_taken[i]) begin
          taken_hit = 1'b1;
          taken_tgt = pred_target[i*AW +: AW];
          stop      = 1'b1;
        end
        if (slot_quiesce[i]) begin
          quiesce_hit = 1'b1;
          stop        = 1'b1;
        end
      end
    end
    next_pc = taken_hit ? taken_tgt : advance_pc(pc, slot_count);
  end
endmodule

// File: rtl/fx_fetch_top.sv
module fx_fetch_top #(
  parameter int NTHR       = 2,
  parameter int AW         = 16,
  parameter int IW         = 32,
  parameter int LINE_BYTES = 16,
  parameter int WIDTH      = 3,
  parameter int SW         = 8,
  parameter logic [31:0] NOP_CODE = 32'h5A5A_0000,
  localparam int TIDW  = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int CW    = $clog2(WIDTH + 1),
  localparam int LBITS = LINE_BYTES * 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fetch_en,
  input  logic [TIDW-1:0]     fetch_tid,
  input  logic [AW-1:0]       fetch_pc,
  input  logic                fetch_fault,
  input  logic                cache_blocked,
  input  logic                intr_pending,
  input  logic [WIDTH-1:0]    pred_taken,
  input  logic [WIDTH*AW-1:0] pred_target,
  input  logic [WIDTH-1:0]    slot_quiesce,
  input  logic                fill_valid,
  input  logic [TIDW-1:0]     fill_tid,
  input  logic [LBITS-1:0]    fill_data,
  input  logic                restart_valid,
  input  logic [TIDW-1:0]     restart_tid,
  output logic                mem_req_valid,
  output logic [TIDW-1:0]     mem_req_tid,
  output logic [AW-1:0]       mem_req_addr,
  output logic [WIDTH-1:0]    out_valid,
  output logic [WIDTH*IW-1:0] out_insn,
  output logic [WIDTH*AW-1:0] out_pc,
  output logic [WIDTH*SW-1:0] out_seq,
  output logic                out_fault,
  output logic [CW-1:0]       out_count,
  output logic [TIDW-1:0]     out_tid,
  output logic [AW-1:0]       out_next_pc,
  output logic [NTHR*2-1:0]   thr_state
);
  import fx_pkg::*;

  localparam int OFFW = $clog2(LINE_BYTES);

  function automatic logic [AW-1:0] line_of(input logic [AW-1:0] p);
    return p & ~AW'(LINE_BYTES - 1);
  endfunction

  thr_st_e st_q [NTHR];
  logic [SW-1:0] seq_q;

  logic [AW-1:0]    buf_tag;
  logic             buf_valid;
  logic [LBITS-1:0] buf_data;

  logic [WIDTH-1:0]    sl_valid;
  logic [WIDTH*IW-1:0] sl_insn;
  logic [WIDTH*AW-1:0] sl_pc;
  logic [CW-1:0]       sl_count;
  logic [AW-1:0]       sl_next;
  logic                sl_quiesce;

  // Named internal events, visible to the checker
  logic ev_go, ev_held, ev_hit, ev_extract, ev_fault, ev_req, ev_fill_ok, ev_restart_fill;

  assign ev_go      = fetch_en && (st_q[fetch_tid] == ST_RUN);
  assign ev_held    = cache_blocked || (intr_pending && (fetch_pc[1:0] != 2'b00));
  assign ev_hit     = ev_go && !ev_held && buf_valid && (buf_tag == line_of(fetch_pc));
  assign ev_extract = ev_hit;
  assign ev_fault   = ev_go && !ev_held && !ev_hit && fetch_fault;
  assign ev_req     = ev_go && !ev_held && !ev_hit && !fetch_fault;
  assign ev_restart_fill = restart_valid && (restart_tid == fill_tid);
  assign ev_fill_ok = fill_valid && (st_q[fill_tid] == ST_WAIT) && !ev_restart_fill;

  assign mem_req_valid = ev_req;
  assign mem_req_tid   = fetch_tid;
  assign mem_req_addr  = line_of(fetch_pc);

  fx_linebuf #(.NTHR(NTHR), .AW(AW), .LINE_BYTES(LINE_BYTES), .TIDW(TIDW)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .req_we(ev_req), .req_tid(fetch_tid), .req_tag(line_of(fetch_pc)),
    .fill_we(ev_fill_ok), .fill_tid(fill_tid), .fill_data(fill_data),
    .rd_tid(fetch_tid), .rd_tag(buf_tag), .rd_valid(buf_valid), .rd_data(buf_data)
  );

  fx_slicer #(.AW(AW), .IW(IW), .LINE_BYTES(LINE_BYTES), .WIDTH(WIDTH), .CW(CW)) u_slice (
    .pc(fetch_pc), .line_data(buf_data),
    .pred_taken(pred_taken), .pred_target(pred_target), .slot_quiesce(slot_quiesce),
    .slot_valid(sl_valid), .slot_insn(sl_insn), .slot_pc(sl_pc),
    .slot_count(sl_count), .next_pc(sl_next), .quiesce_hit(sl_quiesce)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < NTHR; t++) st_q[t] <= ST_RUN;
    end else begin
      for (int t = 0; t < NTHR; t++) begin
        if (restart_valid && restart_tid == TIDW'(t)) begin
          st_q[t] <= ST_RUN;
        end else if (ev_fill_ok && fill_tid == TIDW'(t)) begin
          st_q[t] <= ST_RUN;
        end else if (fetch_tid == TIDW'(t)) begin
          if (ev_req)                        st_q[t] <= ST_WAIT;
          else if (ev_fault)                 st_q[t] <= ST_TRAP;
          else if (ev_extract && sl_quiesce) st_q[t] <= ST_QUIESCE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q       <= '0;
      out_valid   <= '0;
      out_insn    <= '0;
      out_pc      <= '0;
      out_seq     <= '0;
      out_fault   <= 1'b0;
      out_count   <= '0;
      out_tid     <= '0;
      out_next_pc <= '0;
    end else begin
      out_tid   <= fetch_tid;
      out_fault <= ev_fault;
      if (ev_extract) begin
        out_valid   <= sl_valid;
        out_insn    <= sl_insn;
        out_pc      <= sl_pc;
        out_count   <= sl_count;
        out_next_pc <= sl_next;
        seq_q       <= seq_q + SW'(sl_count);
        for (int i = 0; i < WIDTH; i++)
          out_seq[i*SW +: SW] <= sl_valid[i] ? seq_q + SW'(i) : '0;
      end else if (ev_fault) begin
        out_valid   <= WIDTH'(1);
        out_insn    <= (WIDTH*IW)'(NOP_CODE[IW-1:0]);
        out_pc      <= (WIDTH*AW)'(fetch_pc);
        out_count   <= CW'(1);
        out_next_pc <= fetch_pc;
        out_seq     <= (WIDTH*SW)'(seq_q);
        seq_q       <= seq_q + SW'(1);
      end else begin
        out_valid   <= '0;
        out_insn    <= '0;
        out_pc      <= '0;
        out_count   <= '0;
        out_seq     <= '0;
        out_next_pc <= fetch_pc;
      end
    end
  end

  for (genvar t = 0; t < NTHR; t++) begin : g_state
    assign thr_state[t*2 +: 2] = st_q[t];
  end
endmodule

// File: rtl/fx_fetch_chk.sv
module fx_fetch_chk #(
  parameter int WIDTH      = 3,
  parameter int SW         = 8,
  parameter int CW         = 2,
  parameter int AW         = 16,
  parameter int LINE_BYTES = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cache_blocked,
  input logic             intr_pending,
  input logic [AW-1:0]    fetch_pc,
  input logic             mem_req_valid,
  input logic [AW-1:0]    mem_req_addr,
  input logic [WIDTH-1:0] out_valid,
  input logic [SW-1:0]    out_seq0,
  input logic             out_fault,
  input logic [CW-1:0]    out_count,
  input logic             ev_hit,
  input logic             ev_extract,
  input logic             ev_fault
);
  localparam int OFFW = $clog2(LINE_BYTES);

  logic [SW-1:0] exp_seq;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) exp_seq <= '0;
    else if (out_valid[0]) exp_seq <= exp_seq + SW'(out_count);
  end

  // R3
  held_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !cache_blocked && !(intr_pending && fetch_pc[1:0] != 2'b00));
  // R1
  req_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[OFFW-1:0] == '0);
  // R2
  hit_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |-> !mem_req_valid);
  // R8
  count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_count == CW'($countones(out_valid)));
  // R8
  prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_valid + WIDTH'(1)) & out_valid) == '0);
  // R7
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[0] |-> out_seq0 == exp_seq);
  // R10
  fault_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_fault |-> out_count == CW'(1));
  // R12
  extract_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_extract |=> out_valid[0] && !out_fault);
  // R10
  fault_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fault |=> out_fault);
endmodule

bind fx_fetch_top fx_fetch_chk #(
  .WIDTH(WIDTH), .SW(SW), .CW(CW), .AW(AW), .LINE_BYTES(LINE_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cache_blocked(cache_blocked), .intr_pending(intr_pending),
  .fetch_pc(fetch_pc), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
  .out_valid(out_valid), .out_seq0(out_seq[SW-1:0]), .out_fault(out_fault),
  .out_count(out_count), .ev_hit(ev_hit), .ev_extract(ev_extract), .ev_fault(ev_fault)
);

// File: tb/tb_fx_fetch_top.sv
module tb_fx_fetch_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16, IW = 32, LB = 16, W = 3, SW = 8, NT = 2;
  localparam logic [31:0] NOP = 32'h5A5A_0000;

  logic clk = 0, rst_n = 0;
  logic fetch_en = 0, fetch_fault = 0, cache_blocked = 0, intr_pending = 0;
  logic [0:0] fetch_tid = 0, fill_tid = 0, restart_tid = 0;
  logic [AW-1:0] fetch_pc = 0;
  logic [W-1:0] pred_taken = 0, slot_quiesce = 0;
  logic [W*AW-1:0] pred_target;
  logic fill_valid = 0, restart_valid = 0;
  logic [LB*8-1:0] fill_data = 0;
  logic mem_req_valid;
  logic [0:0] mem_req_tid, out_tid;
  logic [AW-1:0] mem_req_addr, out_next_pc;
  logic [W-1:0] out_valid;
  logic [W*IW-1:0] out_insn;
  logic [W*AW-1:0] out_pc;
  logic [W*SW-1:0] out_seq;
  logic out_fault;
  logic [1:0] out_count;
  logic [NT*2-1:0] thr_state;

  fx_fetch_top #(.NTHR(NT), .AW(AW), .IW(IW), .LINE_BYTES(LB), .WIDTH(W), .SW(SW), .NOP_CODE(NOP)) dut (
    .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en), .fetch_tid(fetch_tid), .fetch_pc(fetch_pc),
    .fetch_fault(fetch_fault), .cache_blocked(cache_blocked), .intr_pending(intr_pending),
    .pred_taken(pred_taken), .pred_target(pred_target), .slot_quiesce(slot_quiesce),
    .fill_valid(fill_valid), .fill_tid(fill_tid), .fill_data(fill_data),
    .restart_valid(restart_valid), .restart_tid(restart_tid),
    .mem_req_valid(mem_req_valid), .mem_req_tid(mem_req_tid), .mem_req_addr(mem_req_addr),
    .out_valid(out_valid), .out_insn(out_insn), .out_pc(out_pc), .out_seq(out_seq),
    .out_fault(out_fault), .out_count(out_count), .out_tid(out_tid),
    .out_next_pc(out_next_pc), .thr_state(thr_state)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0, n_fail = 0;
  int sb_seq = 0;
  logic c_req;
  logic [AW-1:0] c_addr;
  logic [0:0] c_tid;

  task automatic ck(input string rq, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] wd(input int t, input logic [15:0] line, input int k);
    return 32'hC000_0000 | (32'(t) << 24) | (32'(line) << 8) | 32'(k);
  endfunction

  function automatic logic [15:0] tgt(input int i);
    return 16'h0800 + 16'(i * 16);
  endfunction

  task automatic do_fetch(input int t, input logic [15:0] pc, input logic [2:0] tk,
                          input logic [2:0] qm, input bit flt);
    @(negedge clk);
    fetch_en = 1; fetch_tid = 1'(t); fetch_pc = pc;
    pred_taken = tk; slot_quiesce = qm; fetch_fault = flt;
    #1;
    c_req = mem_req_valid; c_addr = mem_req_addr; c_tid = mem_req_tid;
    @(negedge clk);
    fetch_en = 0; pred_taken = 0; slot_quiesce = 0; fetch_fault = 0;
  endtask

  task automatic do_fill(input int t, input logic [15:0] line);
    @(negedge clk);
    fill_valid = 1; fill_tid = 1'(t);
    for (int k = 0; k < 4; k++) fill_data[k*32 +: 32] = wd(t, line, k);
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic do_restart(input int t);
    @(negedge clk);
    restart_valid = 1; restart_tid = 1'(t);
    @(negedge clk);
    restart_valid = 0;
  endtask

  task automatic ck_idle(input string rq);
    ck(rq, "out_valid idle", out_valid, 0);
    ck(rq, "out_count idle", out_count, 0);
  endtask

  task automatic ck_extract(input int t, input logic [15:0] line, input logic [15:0] pc,
                            input logic [2:0] tk, input logic [2:0] qm, input string rq);
    int off, n, f;
    logic [15:0] nx;
    off = int'(pc[3:2]);
    n = (4 - off < W) ? 4 - off : W;
    f = n;
    for (int i = W - 1; i >= 0; i--) if (i < n && (tk[i] || qm[i])) f = i;
    if (f < n) n = f + 1;
    nx = (f < W && tk[f] && f < n) ? tgt(f) : pc + 16'(4 * n);
    ck(rq, "no request on hit", c_req, 0);
    ck(rq, "out_count", out_count, n);
    ck(rq, "out_valid", out_valid, (1 << n) - 1);
    ck(rq, "out_next_pc", out_next_pc, nx);
    ck(rq, "out_fault", out_fault, 0);
    ck(rq, "out_tid", out_tid, t);
    for (int i = 0; i < n; i++) begin
      ck(rq, "slot insn", out_insn[i*IW +: IW], wd(t, line, off + i));
      ck(rq, "slot pc", out_pc[i*AW +: AW], line + 16'(4 * (off + i)));
      ck(rq, "slot seq", out_seq[i*SW +: SW], (sb_seq + i) & 255);
    end
    sb_seq = sb_seq + n;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R12: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < W; i++) pred_target[i*AW +: AW] = tgt(i);
    repeat (3) @(negedge clk);
    // Reset state
    ck("R12", "reset out_valid", out_valid, 0);
    ck("R9", "reset thr_state", thr_state, 0);
    ck("R1", "reset mem_req", mem_req_valid, 0);
    rst_n = 1;

    // R1: miss on misaligned PC requests the aligned line
    do_fetch(0, 16'h0106, 0, 0, 0);
    ck("R1", "req valid", c_req, 1);
    ck("R1", "req addr", c_addr, 16'h0100);
    ck("R1", "req tid", c_tid, 0);
    ck("R1", "state WAIT", thr_state[1:0], 1);
    ck_idle("R1");
    // waiting thread does nothing
    do_fetch(0, 16'h0100, 0, 0, 0);
    ck("R11", "no req while waiting", c_req, 0);
    ck_idle("R11");
    do_fill(0, 16'h0100);
    ck("R11", "fill returns RUN", thr_state[1:0], 0);

    // R4 R5 R6 R7 R8 R2: sweep offsets and taken patterns
    for (int off = 0; off < 16; off++)
      for (int tk = 0; tk < 8; tk++) begin
        do_fetch(0, 16'h0100 + 16'(off), 3'(tk), 0, 0);
        ck_extract(0, 16'h0100, 16'h0100 + 16'(off), 3'(tk), 0, "R5");
      end

    // R3: cache blocked
    cache_blocked = 1;
    do_fetch(0, 16'h0200, 0, 0, 0);
    ck("R3", "blocked no req", c_req, 0);
    ck_idle("R3");
    ck("R3", "state unchanged", thr_state[1:0], 0);
    cache_blocked = 0;
    // R3: interrupt pending with misaligned low bits holds; aligned proceeds
    intr_pending = 1;
    do_fetch(1, 16'h0302, 0, 0, 0);
    ck("R3", "intr hold no req", c_req, 0);
    ck("R3", "intr hold state", thr_state[3:2], 0);
    do_fetch(1, 16'h0300, 0, 0, 0);
    ck("R1", "intr aligned req", c_req, 1);
    ck("R1", "req tid 1", c_tid, 1);
    ck("R1", "req addr 0300", c_addr, 16'h0300);
    intr_pending = 0;

    // R11: fill to a running thread is ignored
    do_fill(0, 16'h0999);
    do_fetch(0, 16'h0100, 0, 0, 0);
    ck_extract(0, 16'h0100, 16'h0100, 0, 0, "R11");
    do_fill(1, 16'h0300);
    ck("R11", "t1 RUN after fill", thr_state[3:2], 0);

    // R9: quiesce
    do_fetch(1, 16'h0304, 0, 3'b010, 0);
    ck_extract(1, 16'h0300, 16'h0304, 0, 3'b010, "R9");
    ck("R9", "state QUIESCE", thr_state[3:2], 2);
    do_fetch(1, 16'h0300, 0, 0, 0);
    ck("R9", "parked no req", c_req, 0);
    ck_idle("R9");
    do_restart(1);
    ck("R9", "restart RUN", thr_state[3:2], 0);
    do_fetch(1, 16'h0300, 0, 0, 0);
    ck_extract(1, 16'h0300, 16'h0300, 0, 0, "R9");

    // R10: fault on miss
    do_fetch(0, 16'h0400, 0, 0, 1);
    ck("R10", "fault no req", c_req, 0);
    ck("R10", "fault valid", out_valid, 1);
    ck("R10", "fault flag", out_fault, 1);
    ck("R10", "fault insn", out_insn[IW-1:0], NOP);
    ck("R10", "fault seq", out_seq[SW-1:0], sb_seq & 255);
    ck("R10", "fault next pc", out_next_pc, 16'h0400);
    ck("R10", "state TRAP", thr_state[1:0], 3);
    sb_seq++;
    do_fetch(0, 16'h0100, 0, 0, 0);
    ck_idle("R10");
    do_restart(0);
    do_fetch(0, 16'h0100, 3'b001, 0, 1);
    ck_extract(0, 16'h0100, 16'h0100, 3'b001, 0, "R10");
    ck("R10", "hit fault ignored state", thr_state[1:0], 0);

    // R11: restart beats fill in the same cycle
    do_fetch(1, 16'h0500, 0, 0, 0);
    ck("R1", "req 0500", c_req, 1);
    @(negedge clk);
    fill_valid = 1; fill_tid = 1; restart_valid = 1; restart_tid = 1;
    @(negedge clk);
    fill_valid = 0; restart_valid = 0;
    ck("R11", "restart RUN", thr_state[3:2], 0);
    do_fetch(1, 16'h0500, 0, 0, 0);
    ck("R11", "fill dropped, re-request", c_req, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule